// File: doc/BRIEF.md
# Single-Cycle 32-Bit Processor Core (Seven-Instruction Subset)

This block is a 32-bit processor core that finishes one instruction on every clock edge. It supports seven instructions: register add, register subtract, OR with an immediate, word load, word store, branch-if-equal and an absolute jump.

Each instruction is fetched from a combinational instruction-memory port. The opcode and function fields are decoded into a control word. That control word drives the register file, the immediate extender, the ALU, the operand and write-back multiplexers, and the data-memory port. The register file has two read ports and one write port, and the write lands on the edge that closes the instruction. The fetch unit inside the core chooses the next program counter in one of three ways: sequential, branch-relative or jump-absolute.

The core is intended for a system where instruction and data memories answer within the same cycle. The instruction port is an address out and a word in. The data port is an address, write data and a write enable out, and read data in.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC and all 32 registers are cleared. The first instruction address after reset is 0, and every register then reads 0.
- R2: Opcode 000000 with funct 100000 writes R[rs]+R[rt] into rd. Funct 100010 writes R[rs]-R[rt] into rd. The fields are op [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0] and immediate [15:0].
- R3: Opcode 001101 writes R[rs] OR the zero-extended 16-bit immediate into rt.
- R4: Opcode 100011 loads the data-memory word at R[rs]+sign-extended immediate into rt.
- R5: Opcode 101011 drives R[rt] as write data, with address R[rs]+sign-extended immediate and `dmem_we` high. No other instruction raises `dmem_we`.
- R6: Opcode 000100 compares R[rs] and R[rt] with the ALU subtract. If they are equal, the next PC is PC+4+(sign-extended immediate × 4). If they are not equal, the next PC is PC+4. No register is written.
- R7: Opcode 000010 sets the next PC to {(PC+4)[31:28], instr[25:0], 00}. It writes no register and no memory.
- R8: Register 0 always reads as zero, and writes aimed at it are discarded.
- R9: Any other opcode, or opcode 000000 with any other funct, is a no-op: no register write, no memory write, and the next PC is PC+4.
- R10: Every instruction other than a taken branch or a jump advances the PC by exactly 4 per clock, and the instruction address is always word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Data-memory byte address (ALU result) |
| dmem_wdata | output | 32 | Data to store (second register read port) |
| dmem_we | output | 1 | Data-memory write enable, high only for a store |
| dmem_rdata | input | 32 | Data word returned combinationally for loads |

## Verification
The register file is internal, so a wrong register value is visible only through later instructions. It appears at the data port when a store drives that register as write data or uses it as the base address. It also appears at the instruction address when a branch compares it. The bench therefore follows every arithmetic result, load and discarded write with a store or branch a few instructions later, so a corrupted register shows on the next store that reads it. A wrong PC or a bad decode of a control-flow instruction shows at `imem_addr` in the very next cycle. A stray write enable shows on the same cycle, because each clock is compared against the reference model.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JMP   = 6'b000010;
    localparam logic [5:0] FN_ADD    = 6'b100000;
    localparam logic [5:0] FN_SUB    = 6'b100010;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } alu_op_e;

    typedef enum logic [2:0] {
        K_ADD, K_SUB, K_ORI, K_LOAD, K_STORE, K_BEQ, K_JMP, K_NOP
    } ins_kind_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    src_imm;
        logic    ext_sign;
        logic    wb_mem;
        logic    mem_we;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ins_kind_e  kind,
    output ctrl_t      ctrl
);

    always_comb begin
        unique case (opcode)
            OPC_RTYPE: begin
                if (funct == FN_ADD)      kind = K_ADD;
                else if (funct == FN_SUB) kind = K_SUB;
                else                      kind = K_NOP;
            end
            OPC_ORI:   kind = K_ORI;
            OPC_LOAD:  kind = K_LOAD;
            OPC_STORE: kind = K_STORE;
            OPC_BEQ:   kind = K_BEQ;
            OPC_JMP:   kind = K_JMP;
            default:   kind = K_NOP;
        endcase
    end

    always_comb begin
        ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, ext_sign: 1'b0,
                 wb_mem: 1'b0, mem_we: 1'b0, branch: 1'b0, jump: 1'b0,
                 alu_op: ALU_ADD};
        unique case (kind)
            K_ADD: begin
                ctrl.reg_we = 1'b1;
                ctrl.dst_rd = 1'b1;
            end
            K_SUB: begin
                ctrl.reg_we = 1'b1;
                ctrl.dst_rd = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            K_ORI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            K_LOAD: begin
                ctrl.reg_we   = 1'b1;
                ctrl.src_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.wb_mem   = 1'b1;
            end
            K_STORE: begin
                ctrl.src_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            K_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            K_JMP:   ctrl.jump = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    ra_addr,
    input  logic [AW-1:0]    rb_addr,
    output logic [WIDTH-1:0] ra_data,
    output logic [WIDTH-1:0] rb_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);

    logic [WIDTH-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (wr_en && (wr_addr != '0)) begin
            regs[wr_addr] <= wr_data;
        end
    end

    assign ra_data = (ra_addr == '0) ? '0 : regs[ra_addr];
    assign rb_data = (rb_addr == '0) ? '0 : regs[rb_addr];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_fetch.sv
module sc_fetch #(
    parameter int WIDTH = 32,
    parameter int TGT_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             branch,
    input  logic             equal,
    input  logic             jump,
    input  logic [WIDTH-1:0] offset,
    input  logic [TGT_W-1:0] target,
    output logic [WIDTH-1:0] pc
);

    localparam int HI_W = WIDTH - TGT_W - 2;

    logic [WIDTH-1:0] seq_pc, br_pc, jmp_pc, next_pc;

    assign seq_pc = pc + WIDTH'(4);
    assign br_pc  = seq_pc + {offset[WIDTH-3:0], 2'b00};
    assign jmp_pc = {seq_pc[WIDTH-1 -: HI_W], target, 2'b00};

    always_comb begin
        if (jump)                 next_pc = jmp_pc;
        else if (branch && equal) next_pc = br_pc;
        else                      next_pc = seq_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= next_pc;
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int NREGS = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] imem_addr,
    input  logic [WIDTH-1:0] imem_rdata,
    output logic [WIDTH-1:0] dmem_addr,
    output logic [WIDTH-1:0] dmem_wdata,
    output logic             dmem_we,
    input  logic [WIDTH-1:0] dmem_rdata
);

    localparam int RAW   = $clog2(NREGS);
    localparam int IMM_W = 16;
    localparam int TGT_W = 26;

    logic [5:0]       f_op, f_fn;
    logic [RAW-1:0]   f_rs, f_rt, f_rd, dst;
    logic [IMM_W-1:0] f_imm;
    logic [TGT_W-1:0] f_tgt;
    ins_kind_e        kind;
    ctrl_t            ctrl;
    logic [WIDTH-1:0] rs_val, rt_val, ext_imm, opnd_b, alu_y, wb_val;
    logic             alu_zero;

    assign f_op  = imem_rdata[31:26];
    assign f_rs  = imem_rdata[21 +: RAW];
    assign f_rt  = imem_rdata[16 +: RAW];
    assign f_rd  = imem_rdata[11 +: RAW];
    assign f_fn  = imem_rdata[5:0];
    assign f_imm = imem_rdata[IMM_W-1:0];
    assign f_tgt = imem_rdata[TGT_W-1:0];

    sc_decode u_dec (
        .opcode (f_op),
        .funct  (f_fn),
        .kind   (kind),
        .ctrl   (ctrl)
    );

    assign ext_imm = ctrl.ext_sign ? {{(WIDTH-IMM_W){f_imm[IMM_W-1]}}, f_imm}
                                   : {{(WIDTH-IMM_W){1'b0}}, f_imm};
    assign opnd_b  = ctrl.src_imm ? ext_imm : rt_val;
    assign dst     = ctrl.dst_rd ? f_rd : f_rt;
    assign wb_val  = ctrl.wb_mem ? dmem_rdata : alu_y;

    sc_regfile #(.WIDTH(WIDTH), .DEPTH(NREGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_addr (f_rs),
        .rb_addr (f_rt),
        .ra_data (rs_val),
        .rb_data (rt_val),
        .wr_en   (ctrl.reg_we),
        .wr_addr (dst),
        .wr_data (wb_val)
    );

    sc_alu #(.WIDTH(WIDTH)) u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_val),
        .b    (opnd_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    sc_fetch #(.WIDTH(WIDTH), .TGT_W(TGT_W)) u_fetch (
        .clk    (clk),
        .rst    (rst),
        .branch (ctrl.branch),
        .equal  (alu_zero),
        .jump   (ctrl.jump),
        .offset ({{(WIDTH-IMM_W){f_imm[IMM_W-1]}}, f_imm}),
        .target (f_tgt),
        .pc     (imem_addr)
    );

    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_rdata,
    input logic        dmem_we
);

    logic        started = 1'b0;
    logic [31:0] seq_addr;
    logic [5:0]  op;

    always_ff @(posedge clk) if (rst) started <= 1'b1;

    assign seq_addr = imem_addr + 32'd4;
    assign op       = imem_rdata[31:26];

    // R1: first fetch after reset is from address 0
    a_r1_reset_pc: assert property (@(posedge clk) disable iff (rst)
        (started && $past(rst)) |-> (imem_addr == 32'd0));

    // R5: only the store opcode raises the write enable
    a_r5_store_only: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (op == 6'b101011));

    // R10: non-control instructions advance by one word
    a_r10_seq_step: assert property (@(posedge clk) disable iff (rst)
        (started && !$past(rst) && ($past(op) != 6'b000100) && ($past(op) != 6'b000010))
        |-> (imem_addr == $past(seq_addr)));

    // R7: jump forms the absolute target
    a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
        (started && !$past(rst) && ($past(op) == 6'b000010))
        |-> ((imem_addr[31:28] == $past(seq_addr[31:28])) &&
             (imem_addr[27:2] == $past(imem_rdata[25:0]))));

    // R10: instruction address stays word aligned
    a_r10_aligned: assert property (@(posedge clk) disable iff (rst)
        started |-> (imem_addr[1:0] == 2'b00));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    string       stag [64];

    logic [31:0] m_rf [32];
    logic [31:0] m_dm [64];
    logic [31:0] m_pc;
    string       prev_tag;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sc_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    function automatic logic [31:0] rt_ins(int rs, int rt, int rd, logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Behavioural model: check the outputs of the current cycle, then advance.
    task automatic model_cycle();
        logic [31:0] ins, a, b, sx, zx, nxt;
        int          op, fn, rs, rt, rd;
        string       t;
        ins = imem[m_pc[7:2]];
        op = int'(ins[31:26]); rs = int'(ins[25:21]); rt = int'(ins[20:16]);
        rd = int'(ins[15:11]); fn = int'(ins[5:0]);
        a  = m_rf[rs]; b = m_rf[rt];
        sx = 32'(int'($signed(ins[15:0])));
        zx = {16'd0, ins[15:0]};
        t  = (stag[m_pc[7:2]] == "") ? "R5" : stag[m_pc[7:2]];
        chk(prev_tag, imem_addr, m_pc);
        nxt = m_pc + 4;
        prev_tag = "R10";
        if (op == 43) begin
            chk(t, {31'd0, dmem_we}, 32'd1);
            chk(t, dmem_addr, a + sx);
            chk(t, dmem_wdata, b);
            m_dm[(a + sx) >> 2 & 63] = b;
        end else begin
            chk((op == 2) ? "R7" : "R5", {31'd0, dmem_we}, 32'd0);
            if (op == 0 && fn == 32)      m_rf[rd] = a + b;
            else if (op == 0 && fn == 34) m_rf[rd] = a - b;
            else if (op == 13)            m_rf[rt] = a | zx;
            else if (op == 35)            m_rf[rt] = m_dm[(a + sx) >> 2 & 63];
            else if (op == 4) begin
                prev_tag = "R6";
                if (a == b) nxt = m_pc + 4 + (sx << 2);
            end else if (op == 2) begin
                prev_tag = "R7";
                nxt = {nxt[31:28], ins[25:0], 2'b00};
            end else prev_tag = "R9";
        end
        m_rf[0] = 32'd0;
        m_pc = nxt;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'd0; dmem[i] = 32'h1111_0000 + 32'(i); stag[i] = "";
        end
        dmem[2] = 32'hCAFE_F00D;
        imem[0]  = i_ins(6'h2B, 0, 5, 0);           stag[0]  = "R1";
        imem[1]  = i_ins(6'h0D, 0, 1, 16'h8000);
        imem[2]  = i_ins(6'h0D, 0, 2, 16'h0040);
        imem[3]  = rt_ins(1, 2, 3, 6'h20);
        imem[4]  = rt_ins(2, 1, 4, 6'h22);
        imem[5]  = i_ins(6'h2B, 0, 4, 4);           stag[5]  = "R2";
        imem[6]  = i_ins(6'h2B, 2, 3, -4);          stag[6]  = "R3";
        imem[7]  = i_ins(6'h23, 2, 6, -4);
        imem[8]  = i_ins(6'h23, 0, 7, 8);
        imem[9]  = rt_ins(1, 1, 0, 6'h20);
        imem[10] = i_ins(6'h2B, 0, 0, 12);          stag[10] = "R8";
        imem[11] = {6'h3F, 5'd0, 5'd2, 16'h1234};
        imem[12] = rt_ins(1, 1, 2, 6'h25);
        imem[13] = i_ins(6'h2B, 0, 2, 16);          stag[13] = "R9";
        imem[14] = i_ins(6'h04, 1, 2, 5);
        imem[15] = i_ins(6'h04, 3, 3, 2);
        imem[16] = i_ins(6'h0D, 0, 8, 1);
        imem[17] = i_ins(6'h0D, 0, 8, 2);
        imem[18] = i_ins(6'h2B, 0, 7, 20);          stag[18] = "R4";
        imem[19] = {6'h02, 26'd22};
        imem[20] = i_ins(6'h0D, 0, 9, 7);
        imem[22] = i_ins(6'h04, 6, 6, 1);
        imem[23] = i_ins(6'h0D, 0, 9, 9);
        imem[24] = {6'h02, 26'd26};
        imem[25] = i_ins(6'h2B, 0, 9, 24);
        imem[26] = i_ins(6'h04, 0, 0, -1);
        for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
        for (int i = 0; i < 64; i++) m_dm[i] = dmem[i];
        m_pc = 32'd0;
        prev_tag = "R1";

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        chk("R1", imem_addr, 32'd0);
        for (int c = 0; c < 60; c++) begin
            model_cycle();
            @(negedge clk);
        end
        for (int i = 0; i < 16; i++) chk("R5", dmem[i], m_dm[i]);
        chk("R8", dmem[3], 32'd0);
        chk("R4", dmem[5], 32'hCAFE_F00D);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule